// File: doc/BRIEF.md
# FPGA Configuration Load Sequencer

This block drives the configuration sequence of a target FPGA that takes its bitstream over a parallel byte port. A one-cycle start pulse begins a run. The byte count and the enable choice are sampled with that pulse. The sequencer first releases the open-drain INIT line, which has been held low since reset. It then pulses the active-low PROGRAM pin for a set number of cycles and waits for the target to raise INIT. That rise means the target has cleared its configuration memory.

After INIT rises, the block takes the bitstream from a valid/ready byte stream. It puts each byte on the data port with a one-cycle write strobe. After the last byte it waits for DONE. Each wait has its own cycle-count timeout. On exit, a one-cycle done pulse presents a 2-bit result code and drops the enable output.

A start pulse with the absent flag raised finishes at once and never touches PROGRAM. INIT and DONE are asynchronous to the block and pass through two-flop synchronisers before use.

Top module: `fpga_cfg_loader`

## Requirements
- R1: After reset, prog_no is 1, init_oe_o is 1 (INIT held low), en_o is 0, busy_o is 0, done_o is 0 and result_o is 0.
- R2: A start with absent_i=1 while idle raises done_o in the next cycle with result_o=1 (target absent), leaves busy_o low and never drives prog_no low.
- R3: On a start with absent_i=0, prog_no is low for exactly PULSE_CYC cycles, and init_oe_o is 0 whenever prog_no is low.
- R4: en_o equals the en_cfg_i value sampled at start for every cycle that busy_o is high, and en_o is 0 whenever busy_o is low.
- R5: After synchronised INIT reads 1, exactly size_i bytes are written in stream order, with one wr_o pulse per byte and dat_o valid during that pulse. Size 0 writes nothing.
- R6: s_ready_o is high only in the transfer phase. A byte is taken only in a cycle with s_valid_i and s_ready_o both high, and gaps in s_valid_i do not lose or repeat bytes.
- R7: If INIT does not read high, done_o rises with result_o=2 exactly INIT_TMO cycles after the first cycle with prog_no high again, and no byte is taken.
- R8: If DONE does not read high, done_o rises with result_o=3 exactly DONE_TMO cycles after the last wr_o pulse. DONE_TMO defaults to ten times INIT_TMO.
- R9: If DONE reads high after the transfer, the run ends with result_o=0.
- R10: A start pulse while busy_o is high is ignored: no second PROGRAM pulse and no second done pulse.
- R11: done_o is high for exactly one cycle per run, and busy_o falls in that same cycle. result_o holds its value until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle start pulse |
| absent_i | input | 1 | Target not configured or not present |
| en_cfg_i | input | 1 | Drive the enable output during the run |
| size_i | input | CNT_W | Number of bitstream bytes |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_ready_o | output | 1 | Stream byte accepted when valid |
| init_i | input | 1 | INIT line level (asynchronous) |
| init_oe_o | output | 1 | 1 pulls the open-drain INIT line low, 0 releases it |
| prog_no | output | 1 | PROGRAM, active low |
| en_o | output | 1 | Target enable |
| dat_o | output | 8 | Configuration data port |
| wr_o | output | 1 | One-cycle write strobe per byte |
| done_pin_i | input | 1 | DONE line level (asynchronous) |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| result_o | output | 2 | 0 ok, 1 absent, 2 INIT timeout, 3 DONE timeout |

## Verification
The assertions check on every cycle that INIT is released while PROGRAM is low, that the enable is low when idle, and that the ready signal is tied to the busy phase. They also check that each strobe follows an accepted byte and carries that byte, that done lasts one cycle and coincides with busy falling, and that an absent start yields code 1. Other behaviours need the bench's scenarios: the exact PROGRAM pulse length, the byte order across stream gaps, the exact timeout distances, the ignored start during a run, and the mapping from each failure point to its code.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_WINIT, ST_XFER, ST_WDONE
  } cfg_st_e;

  localparam logic [1:0] RES_OK     = 2'd0;
  localparam logic [1:0] RES_ABSENT = 2'd1;
  localparam logic [1:0] RES_NOINIT = 2'd2;
  localparam logic [1:0] RES_NODONE = 2'd3;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/cfg_tmr.sv
module cfg_tmr #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cfg_byte_port.sv
module cfg_byte_port #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] size_i,
  input  logic             take_i,
  input  logic [7:0]       data_i,
  output logic             empty_o,
  output logic             last_o,
  output logic [7:0]       dat_o,
  output logic             wr_o
);
  logic [CNT_W-1:0] left_q;
  logic [7:0]       dat_q;
  logic             wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      dat_q  <= '0;
      wr_q   <= 1'b0;
    end else begin
      wr_q <= take_i;
      if (load_i)      left_q <= size_i;
      else if (take_i) left_q <= left_q - 1'b1;
      if (take_i)      dat_q <= data_i;
    end
  end

  assign empty_o = (left_q == '0);
  assign last_o  = (left_q == CNT_W'(1));
  assign dat_o   = dat_q;
  assign wr_o    = wr_q;
endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
  import cfg_pkg::*;
#(
  parameter int PULSE_CYC = 20,
  parameter int INIT_TMO  = 1000,
  parameter int DONE_TMO  = 10 * INIT_TMO,
  parameter int CNT_W     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             absent_i,
  input  logic             en_cfg_i,
  input  logic [CNT_W-1:0] size_i,
  input  logic             s_valid_i,
  input  logic [7:0]       s_data_i,
  output logic             s_ready_o,
  input  logic             init_i,
  output logic             init_oe_o,
  output logic             prog_no,
  output logic             en_o,
  output logic [7:0]       dat_o,
  output logic             wr_o,
  input  logic             done_pin_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       result_o
);
  localparam int MAX_A = (INIT_TMO > PULSE_CYC) ? INIT_TMO : PULSE_CYC;
  localparam int MAX_T = (DONE_TMO > MAX_A) ? DONE_TMO : MAX_A;
  localparam int TW    = $clog2(MAX_T + 1);

  cfg_st_e       st_q;
  logic [1:0]    sync_q;
  logic          init_s, done_s;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          bp_load, bp_empty, bp_last, take;
  logic          prog_q, hold_q, en_q, done_q;
  logic [1:0]    res_q;

  cfg_sync #(.W(2)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({done_pin_i, init_i}),
    .q_o   (sync_q)
  );
  assign init_s = sync_q[0];
  assign done_s = sync_q[1];

  cfg_tmr #(.TW(TW)) i_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .val_i (tmr_val),
    .zero_o(tmr_zero)
  );

  assign take = s_valid_i && s_ready_o;

  cfg_byte_port #(.CNT_W(CNT_W)) i_port (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (bp_load),
    .size_i (size_i),
    .take_i (take),
    .data_i (s_data_i),
    .empty_o(bp_empty),
    .last_o (bp_last),
    .dat_o  (dat_o),
    .wr_o   (wr_o)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    bp_load  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i && !absent_i) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(PULSE_CYC - 1);
        bp_load  = 1'b1;
      end
      ST_PROG: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(INIT_TMO - 1);
      end
      ST_WINIT: if (init_s && bp_empty) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(DONE_TMO - 1);
      end
      ST_XFER: if (take && bp_last) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(DONE_TMO - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      prog_q <= 1'b1;
      hold_q <= 1'b1;
      en_q   <= 1'b0;
      done_q <= 1'b0;
      res_q  <= RES_OK;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          if (absent_i) begin
            res_q  <= RES_ABSENT;
            done_q <= 1'b1;
          end else begin
            st_q   <= ST_PROG;
            prog_q <= 1'b0;
            hold_q <= 1'b0;
            en_q   <= en_cfg_i;
          end
        end
        ST_PROG: if (tmr_zero) begin
          prog_q <= 1'b1;
          st_q   <= ST_WINIT;
        end
        ST_WINIT: begin
          if (init_s) begin
            st_q <= bp_empty ? ST_WDONE : ST_XFER;
          end else if (tmr_zero) begin
            st_q   <= ST_IDLE;
            res_q  <= RES_NOINIT;
            done_q <= 1'b1;
            en_q   <= 1'b0;
          end
        end
        ST_XFER: if (take && bp_last) st_q <= ST_WDONE;
        ST_WDONE: begin
          if (done_s || tmr_zero) begin
            st_q   <= ST_IDLE;
            res_q  <= done_s ? RES_OK : RES_NODONE;
            done_q <= 1'b1;
            en_q   <= 1'b0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign s_ready_o = (st_q == ST_XFER);
  assign busy_o    = (st_q != ST_IDLE);
  assign prog_no   = prog_q;
  assign init_oe_o = hold_q;
  assign en_o      = en_q;
  assign done_o    = done_q;
  assign result_o  = res_q;
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       absent_i,
  input logic       s_valid_i,
  input logic [7:0] s_data_i,
  input logic       s_ready_o,
  input logic       init_oe_o,
  input logic       prog_no,
  input logic       en_o,
  input logic [7:0] dat_o,
  input logic       wr_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] result_o
);
  a_r3_init_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_no |-> !init_oe_o);

  a_r4_en_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !en_o);

  a_r6_ready_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> busy_o);

  a_r5_strobe_follows_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && s_ready_o) |=> (wr_o && dat_o == $past(s_data_i)));

  a_r5_no_stray_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s_valid_i && s_ready_o) |=> !wr_o);

  a_r11_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r11_busy_falls_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r2_absent_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && absent_i && !busy_o) |=> (done_o && result_o == 2'd1 && !busy_o));

  a_r10_start_busy_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o && s_ready_o) |=> !done_o);
endmodule

bind fpga_cfg_loader cfg_loader_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .absent_i (absent_i),
  .s_valid_i(s_valid_i),
  .s_data_i (s_data_i),
  .s_ready_o(s_ready_o),
  .init_oe_o(init_oe_o),
  .prog_no  (prog_no),
  .en_o     (en_o),
  .dat_o    (dat_o),
  .wr_o     (wr_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/test_fpga_cfg_loader.sv
module test_fpga_cfg_loader;
  localparam int CLK_P = 10;
  localparam int PULSE = 5;
  localparam int ITMO  = 30;
  localparam int DTMO  = 10 * ITMO;
  localparam int CW    = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, absent = 1'b0, en_cfg = 1'b0;
  logic [CW-1:0] size = '0;
  logic s_valid, s_ready, init_oe, prog_n, en, wr, busy, done, tgt_done_q;
  logic [7:0] s_data, dat;
  logic [1:0] result;
  logic init_line;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  bit clr = 0, src_en = 0, gap = 0, init_ok = 0, done_ok = 0, en_exp = 0;
  int exp_size = 0, src_idx = 0, seed = 0;
  int low_run = 0, last_low = 0, prog_runs = 0, rise_cyc = 0;
  int wr_cnt = 0, last_wr_cyc = 0, done_cnt = 0, done_cyc = 0;
  int en_bad = 0, rel_bad = 0, idly = 0;
  bit tgt_init = 0, tgt_done = 0;
  logic [7:0] got [16];

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] pat(int k);
    return 8'((k * 37 + seed) & 255);
  endfunction

  assign init_line = init_oe ? 1'b0 : tgt_init;
  assign tgt_done_q = tgt_done;
  assign s_data  = pat(src_idx);
  assign s_valid = src_en && (!gap || (cyc % 3) != 0);

  fpga_cfg_loader #(.PULSE_CYC(PULSE), .INIT_TMO(ITMO), .DONE_TMO(DTMO), .CNT_W(CW))
  i_fpga_cfg_loader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .absent_i(absent),
    .en_cfg_i(en_cfg), .size_i(size), .s_valid_i(s_valid), .s_data_i(s_data),
    .s_ready_o(s_ready), .init_i(init_line), .init_oe_o(init_oe), .prog_no(prog_n),
    .en_o(en), .dat_o(dat), .wr_o(wr), .done_pin_i(tgt_done_q), .busy_o(busy),
    .done_o(done), .result_o(result)
  );

  always @(posedge clk) begin
    if (clr) src_idx <= 0;
    else if (s_valid && s_ready) src_idx <= src_idx + 1;
  end

  // monitor and target model
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (clr) begin
      low_run = 0; last_low = 0; prog_runs = 0; wr_cnt = 0;
      done_cnt = 0; en_bad = 0; rel_bad = 0;
    end else begin
      if (!prog_n) low_run = low_run + 1;
      else if (low_run != 0) begin
        last_low = low_run; prog_runs = prog_runs + 1; rise_cyc = cyc; low_run = 0;
      end
      if (!prog_n && init_oe) rel_bad = rel_bad + 1;
      if (wr) begin
        if (wr_cnt < 16) got[wr_cnt] = dat;
        wr_cnt = wr_cnt + 1; last_wr_cyc = cyc;
      end
      if (done) begin done_cnt = done_cnt + 1; done_cyc = cyc; end
      if (busy && en !== en_exp) en_bad = en_bad + 1;
      if (!busy && en) en_bad = en_bad + 1;
    end
    if (!prog_n) begin tgt_init = 0; tgt_done = 0; idly = 0; end
    else begin
      if (init_ok && !tgt_init) begin idly = idly + 1; if (idly >= 3) tgt_init = 1; end
      if (done_ok && tgt_init && wr_cnt == exp_size) tgt_done = 1;
    end
  end

  task automatic chk(bit ok, string tag, int act, int expv);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk); clr = 1;
    @(negedge clk);
    @(negedge clk); clr = 0;
  endtask

  task automatic wait_done();
    int g = 0;
    while (done_cnt == 0 && g < 2000) begin @(negedge clk); g++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic run_load(int n, bit e, bit iok, bit dok, bit gp);
    int exp_res;
    int exp_wr;
    clear_mon();
    seed = n * 11 + 5; en_cfg = e; en_exp = e; init_ok = iok; done_ok = dok;
    gap = gp; exp_size = n; size = CW'(n); src_en = 1;
    start = 1; @(negedge clk); start = 0;
    wait_done();
    exp_res = !iok ? 2 : (!dok ? 3 : 0);
    exp_wr  = iok ? n : 0;
    if (!iok)      chk(result == 2'(exp_res), "R7 result", result, exp_res);
    else if (!dok) chk(result == 2'(exp_res), "R8 result", result, exp_res);
    else           chk(result == 2'(exp_res), "R9 result", result, exp_res);
    chk(done_cnt == 1, "R11 done pulses", done_cnt, 1);
    chk(prog_runs == 1 && last_low == PULSE, "R3 prog low cycles", last_low, PULSE);
    chk(rel_bad == 0, "R3 init released", rel_bad, 0);
    chk(en_bad == 0, "R4 enable follows run", en_bad, 0);
    chk(wr_cnt == exp_wr, "R5 strobe count", wr_cnt, exp_wr);
    for (int k = 0; k < exp_wr && k < 16; k++)
      chk(got[k] == pat(k), gp ? "R6 byte with gaps" : "R5 byte order", got[k], pat(k));
    if (!iok) begin
      chk(done_cyc - rise_cyc == ITMO, "R7 init timeout", done_cyc - rise_cyc, ITMO);
      chk(src_idx == 0, "R6 nothing taken", src_idx, 0);
    end
    if (iok && !dok && n > 0)
      chk(done_cyc - last_wr_cyc == DTMO, "R8 done timeout", done_cyc - last_wr_cyc, DTMO);
    chk(busy == 0, "R11 busy low at end", busy, 0);
    src_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(prog_n == 1 && init_oe == 1 && en == 0, "R1 pins in reset", {prog_n, init_oe, en}, 3'b110);
    chk(busy == 0 && done == 0 && result == 0, "R1 status in reset", {busy, done, result}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(prog_n == 1 && init_oe == 1, "R1 after release", {prog_n, init_oe}, 2'b11);

    // absent target
    clear_mon();
    absent = 1; start = 1; @(negedge clk); start = 0; absent = 0;
    chk(done == 1 && result == 2'd1, "R2 absent code", {done, result}, 3'b101);
    chk(busy == 0, "R2 not busy", busy, 0);
    repeat (6) @(negedge clk);
    chk(prog_runs == 0 && low_run == 0, "R2 prog untouched", prog_runs + low_run, 0);
    chk(done_cnt == 1, "R11 absent one pulse", done_cnt, 1);

    // sweep of sizes, enable, stream gaps
    for (int n = 0; n <= 6; n++) run_load(n, n[0], 1, 1, n[1]);
    run_load(3, 1, 0, 1, 0);
    run_load(4, 1, 1, 0, 1);
    run_load(0, 0, 1, 0, 0);
    run_load(1, 1, 1, 0, 0);

    // start while busy
    clear_mon();
    seed = 77; en_cfg = 1; en_exp = 1; init_ok = 1; done_ok = 1; gap = 1;
    exp_size = 6; size = CW'(6); src_en = 1;
    start = 1; @(negedge clk); start = 0;
    begin
      int g = 0;
      while (wr_cnt < 2 && g < 500) begin @(negedge clk); g++; end
    end
    start = 1; @(negedge clk); start = 0;
    wait_done();
    repeat (20) @(negedge clk);
    chk(prog_runs == 1, "R10 single prog pulse", prog_runs, 1);
    chk(done_cnt == 1, "R10 single done", done_cnt, 1);
    chk(wr_cnt == 6 && result == 2'd0, "R10 run unaffected", wr_cnt, 6);
    chk(busy == 0, "R10 idle after", busy, 0);
    src_en = 0;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total = total + 1; bad = bad + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule